// File: doc/BRIEF.md
# Bitwise Bus Arbitration Transmitter

This block drives the opening section of a frame on a wired-AND serial bus and works out whether this node keeps the bus. A frame builder hands it an 11-bit identifier and a remote-request flag with a one-cycle `start`. From then on the block presents one bit per bit time on `tx_bit`. At each `bit_stb` it compares that bit with the bus level on `rx_bit`, which is the level sampled in that bit time. The section it sends is a dominant start bit, then the identifier most-significant bit first, then the request flag. Logic 0 is dominant and logic 1 is recessive. Complementary stuff bits are inserted into the stream, and every bit, stuffed or not, is compared against the bus.

If this node sends recessive and finds the bus dominant, it has lost. It stops driving in that same bit, reports the position of the losing bit, and listens to the rest of the section. While listening it removes stuff bits and collects the winning node's identifier and request flag. A dominant bit that reads back recessive is a bit error, not a loss. After a loss or a bit error the output stays recessive until the frame builder signals `frame_end`. A node that matches the bus through the request flag reports a win and hands the bus back to the frame builder.

Top module: `can_arb_unit`

## Requirements
- R1: During reset and while idle, `tx_bit` is 1 (recessive), `busy` is 0 and no result pulse is raised. Asserting `rst_n` low in the middle of a frame returns the block to this state at once.
- R2: A `start` pulse while idle loads a 13-bit section: position 0 is a dominant start bit, positions 1 to 11 are `id_in[10]` down to `id_in[0]`, and position 12 is `rtr_in`. The bit on `tx_bit` changes only after a `bit_stb`.
- R3: After five consecutive equal bits on the bus stream, the next bit sent is their complement. That stuff bit starts a new run of length one and does not advance the section position.
- R4: If every bit through position 12 matches the bus, `arb_won` is high for exactly one cycle, in the cycle after the strobe that samples position 12. In that same cycle `busy` is 0 and `tx_bit` is recessive.
- R5: If a data bit is sent as 1 and sampled as 0, `arb_lost` is high for one cycle after that strobe. `lost_pos` then holds the section position of that bit (0 start, 1 to 11 identifier from the MSB, 12 request flag). From that cycle on, `tx_bit` is 1 until `frame_end`.
- R6: When two nodes contend, the numerically lower 13-bit section wins. Identical sections both report a win.
- R7: After a loss the block keeps sampling and drops stuff bits. `rx_done` is high for one cycle after the strobe that samples position 12. `rx_id` and `rx_rtr` then hold the identifier and request flag seen on the bus.
- R8: A data bit sent as 0 and sampled as 1 raises `bit_err` for one cycle, with no `arb_lost`. `tx_bit` then stays 1 and later strobes have no effect until `frame_end`.
- R9: A stuff bit whose sampled value differs from the value sent raises `bit_err` and not `arb_lost`, in either direction.
- R10: `frame_end` returns the block from any busy state to idle in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a frame with `id_in` and `rtr_in` (accepted only while idle) |
| id_in | input | 11 | Identifier to send |
| rtr_in | input | 1 | Request flag sent after the identifier |
| bit_stb | input | 1 | One-cycle strobe at the sample point of each bit |
| rx_bit | input | 1 | Bus level at the sample point |
| frame_end | input | 1 | End of the current frame; releases the block |
| tx_bit | output | 1 | Bit driven toward the transceiver (1 recessive) |
| busy | output | 1 | Block is inside a frame |
| arb_won | output | 1 | One-cycle win pulse |
| arb_lost | output | 1 | One-cycle loss pulse |
| lost_pos | output | 4 | Section position of the losing bit |
| bit_err | output | 1 | One-cycle bit error pulse |
| rx_done | output | 1 | One-cycle pulse when the winner's section has been collected |
| rx_id | output | 11 | Identifier collected from the bus |
| rx_rtr | output | 1 | Request flag collected from the bus |

## Verification
The hardest case to reach is a mismatch that lands exactly on a stuff bit. In a real contention every node computes the same stuff bit, so that mismatch never arises. The bench forces it by acting as the bus itself. It sends an all-dominant identifier until the stuff bit is due, then holds the line dominant. Contention between two nodes is modelled the same way: the bench drives the stuffed stream of the lower section onto `rx_bit` and works out the loss position, including losses just after a stuff bit and losses on the final request bit.

// File: rtl/can_arb_pkg.sv
package can_arb_pkg;
  // Sequencer states for the arbitration section
  typedef enum logic [1:0] {
    ARB_IDLE   = 2'd0,  // waiting for start
    ARB_SEND   = 2'd1,  // transmitting and comparing
    ARB_LISTEN = 2'd2,  // lost, receiving remaining section
    ARB_HOLD   = 2'd3   // recessive until frame_end
  } arb_state_e;
endpackage

// File: rtl/can_arb_stuff.sv
// Run-length tracker on the sampled bus stream. Used for both stuff
// insertion while sending and stuff removal while listening.
module can_arb_stuff #(
  parameter int RUN_LEN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  input  logic bus_bit,
  output logic stuff_due,
  output logic run_lvl
);
  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(RUN_LEN);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             lvl_q, lvl_n;
  logic             en;

  assign en = clr | adv;

  always_comb begin
    cnt_n = cnt_q;
    lvl_n = lvl_q;
    if (clr) begin
      cnt_n = '0;
      lvl_n = 1'b1;
    end else if (adv) begin
      if ((cnt_q == '0) || (cnt_q == RUN_MAX) || (bus_bit != lvl_q)) begin
        cnt_n = CNT_W'(1);
        lvl_n = bus_bit;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b1;
    end else if (en) begin
      cnt_q <= cnt_n;
      lvl_q <= lvl_n;
    end
  end

  assign stuff_due = (cnt_q == RUN_MAX);
  assign run_lvl   = lvl_q;
endmodule

// File: rtl/can_arb_shift.sv
// Generic shift register: loads in parallel and shifts out from the MSB,
// or shifts serial data in at the LSB.
module can_arb_shift #(
  parameter int WIDTH = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] par_in,
  input  logic             shift,
  input  logic             ser_in,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_n;
  logic             en;

  assign en = load | shift;

  always_comb begin
    q_n = q;
    if (load)       q_n = par_in;
    else if (shift) q_n = {q[WIDTH-2:0], ser_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= q_n;
  end
endmodule

// File: rtl/can_arb_ctrl.sv
// Sequencer: walks the section, compares each sent bit against the bus,
// and decides win, loss or bit error.
module can_arb_ctrl
  import can_arb_pkg::*;
#(
  parameter int FRAME_W = 13,
  parameter int POS_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             bit_stb,
  input  logic             rx_bit,
  input  logic             frame_end,
  input  logic             stuff_due,
  input  logic             run_lvl,
  input  logic             data_bit,
  output logic             tx_bit,
  output logic             busy,
  output logic             load_frame,
  output logic             shift_frame,
  output logic             clr_run,
  output logic             adv_run,
  output logic             cap_clr,
  output logic             cap_en,
  output logic             arb_won,
  output logic             arb_lost,
  output logic             bit_err,
  output logic             rx_done,
  output logic [POS_W-1:0] lost_pos
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_W - 1);

  arb_state_e       st_q, st_n;
  logic [POS_W-1:0] pos_q, pos_n;
  logic [POS_W-1:0] lpos_q, lpos_n;
  logic             won_n, lost_n, berr_n, done_n;
  logic             tx_cur;
  logic             lose_now, dom_err;
  logic             is_last;

  // Bit currently presented: a stuff bit is the complement of the run
  assign tx_cur   = stuff_due ? ~run_lvl : data_bit;
  assign lose_now = tx_cur & ~rx_bit;
  assign dom_err  = ~tx_cur & rx_bit;
  assign is_last  = (pos_q == LAST_POS);

  always_comb begin
    st_n        = st_q;
    pos_n       = pos_q;
    lpos_n      = lpos_q;
    won_n       = 1'b0;
    lost_n      = 1'b0;
    berr_n      = 1'b0;
    done_n      = 1'b0;
    load_frame  = 1'b0;
    shift_frame = 1'b0;
    clr_run     = 1'b0;
    adv_run     = 1'b0;
    cap_clr     = 1'b0;
    cap_en      = 1'b0;
    unique case (st_q)
      ARB_IDLE: begin
        if (start) begin
          st_n       = ARB_SEND;
          pos_n      = '0;
          load_frame = 1'b1;
          clr_run    = 1'b1;
          cap_clr    = 1'b1;
        end
      end
      ARB_SEND: begin
        if (frame_end) begin
          st_n = ARB_IDLE;
        end else if (bit_stb) begin
          adv_run = 1'b1;
          if (stuff_due) begin
            // stuff bit: any mismatch is a bit error
            if (rx_bit != tx_cur) begin
              berr_n = 1'b1;
              st_n   = ARB_HOLD;
            end
          end else if (dom_err) begin
            berr_n = 1'b1;
            st_n   = ARB_HOLD;
          end else begin
            cap_en = (pos_q != '0);
            if (lose_now) begin
              lost_n = 1'b1;
              lpos_n = pos_q;
            end
            if (is_last) begin
              if (lose_now) begin
                done_n = 1'b1;
                st_n   = ARB_HOLD;
              end else begin
                won_n = 1'b1;
                st_n  = ARB_IDLE;
              end
            end else begin
              pos_n       = pos_q + 1'b1;
              shift_frame = 1'b1;
              if (lose_now) st_n = ARB_LISTEN;
            end
          end
        end
      end
      ARB_LISTEN: begin
        if (frame_end) begin
          st_n = ARB_IDLE;
        end else if (bit_stb) begin
          adv_run = 1'b1;
          if (!stuff_due) begin
            cap_en = 1'b1;
            if (is_last) begin
              done_n = 1'b1;
              st_n   = ARB_HOLD;
            end else begin
              pos_n = pos_q + 1'b1;
            end
          end
        end
      end
      ARB_HOLD: begin
        if (frame_end) st_n = ARB_IDLE;
      end
      default: st_n = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ARB_IDLE;
      pos_q    <= '0;
      lpos_q   <= '0;
      arb_won  <= 1'b0;
      arb_lost <= 1'b0;
      bit_err  <= 1'b0;
      rx_done  <= 1'b0;
    end else begin
      st_q     <= st_n;
      pos_q    <= pos_n;
      if (lost_n) lpos_q <= lpos_n;
      arb_won  <= won_n;
      arb_lost <= lost_n;
      bit_err  <= berr_n;
      rx_done  <= done_n;
    end
  end

  assign tx_bit   = (st_q == ARB_SEND) ? tx_cur : 1'b1;
  assign busy     = (st_q != ARB_IDLE);
  assign lost_pos = lpos_q;
endmodule

// File: rtl/can_arb_unit.sv
// Top level: reset release, section shifter, run tracker, capture register
// and sequencer.
module can_arb_unit #(
  parameter  int ID_W    = 11,
  parameter  int RUN_LEN = 5,
  parameter  int SYNC_N  = 2,
  localparam int FRAME_W = ID_W + 2,
  localparam int POS_W   = $clog2(FRAME_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ID_W-1:0]  id_in,
  input  logic             rtr_in,
  input  logic             bit_stb,
  input  logic             rx_bit,
  input  logic             frame_end,
  output logic             tx_bit,
  output logic             busy,
  output logic             arb_won,
  output logic             arb_lost,
  output logic [POS_W-1:0] lost_pos,
  output logic             bit_err,
  output logic             rx_done,
  output logic [ID_W-1:0]  rx_id,
  output logic             rx_rtr
);
  localparam int CAP_W = ID_W + 1;

  // Reset: asserted asynchronously, released on the clock
  logic [SYNC_N-1:0] rst_pipe;
  logic              rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_N-2:0], 1'b1};
  end
  assign rst_n_int = rst_pipe[SYNC_N-1];

  logic               load_frame, shift_frame;
  logic               clr_run, adv_run, stuff_due, run_lvl;
  logic               cap_clr, cap_en;
  logic [FRAME_W-1:0] frame_q;
  logic [CAP_W-1:0]   cap_q;

  can_arb_shift #(.WIDTH(FRAME_W)) u_frame (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .load   (load_frame),
    .par_in ({1'b0, id_in, rtr_in}),
    .shift  (shift_frame),
    .ser_in (1'b1),
    .q      (frame_q)
  );

  can_arb_stuff #(.RUN_LEN(RUN_LEN)) u_stuff (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .clr       (clr_run),
    .adv       (adv_run),
    .bus_bit   (rx_bit),
    .stuff_due (stuff_due),
    .run_lvl   (run_lvl)
  );

  can_arb_shift #(.WIDTH(CAP_W)) u_capture (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .load   (cap_clr),
    .par_in ('0),
    .shift  (cap_en),
    .ser_in (rx_bit),
    .q      (cap_q)
  );

  can_arb_ctrl #(.FRAME_W(FRAME_W), .POS_W(POS_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .start       (start),
    .bit_stb     (bit_stb),
    .rx_bit      (rx_bit),
    .frame_end   (frame_end),
    .stuff_due   (stuff_due),
    .run_lvl     (run_lvl),
    .data_bit    (frame_q[FRAME_W-1]),
    .tx_bit      (tx_bit),
    .busy        (busy),
    .load_frame  (load_frame),
    .shift_frame (shift_frame),
    .clr_run     (clr_run),
    .adv_run     (adv_run),
    .cap_clr     (cap_clr),
    .cap_en      (cap_en),
    .arb_won     (arb_won),
    .arb_lost    (arb_lost),
    .bit_err     (bit_err),
    .rx_done     (rx_done),
    .lost_pos    (lost_pos)
  );

  assign rx_id  = cap_q[CAP_W-1:1];
  assign rx_rtr = cap_q[0];
endmodule

// File: rtl/can_arb_unit_chk.sv
module can_arb_unit_chk #(
  parameter int FRAME_W = 13,
  parameter int POS_W   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             bit_stb,
  input logic             rx_bit,
  input logic             tx_bit,
  input logic             busy,
  input logic             arb_won,
  input logic             arb_lost,
  input logic             bit_err,
  input logic             rx_done,
  input logic [POS_W-1:0] lost_pos
);
  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_W - 1);

  AST_IDLE_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx_bit); // R1
  AST_TX_HOLDS_BETWEEN_STB: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(bit_stb) && !$past(start)) |-> $stable(tx_bit)); // R2
  AST_WON_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    arb_won |-> (!busy && $past(bit_stb))); // R4
  AST_LOST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> $past(bit_stb && tx_bit && !rx_bit)); // R5
  AST_LOST_WITHDRAWS: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> (tx_bit && busy && lost_pos <= LAST)); // R5
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arb_won, arb_lost, bit_err})); // R6
  AST_DONE_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> $past(bit_stb)); // R7
  AST_BITERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_err |-> $past(bit_stb && (rx_bit != tx_bit))); // R8
endmodule

bind can_arb_unit can_arb_unit_chk #(.FRAME_W(FRAME_W), .POS_W(POS_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .bit_stb  (bit_stb),
  .rx_bit   (rx_bit),
  .tx_bit   (tx_bit),
  .busy     (busy),
  .arb_won  (arb_won),
  .arb_lost (arb_lost),
  .bit_err  (bit_err),
  .rx_done  (rx_done),
  .lost_pos (lost_pos)
);

// File: tb/can_arb_unit_tb_top.sv
module can_arb_unit_tb_top;
  localparam int WD_LIMIT = 100000;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [10:0] id_in;
  logic        rtr_in;
  logic        bit_stb;
  logic        rx_bit;
  logic        frame_end;
  logic        tx_bit, busy, arb_won, arb_lost, bit_err, rx_done, rx_rtr;
  logic [3:0]  lost_pos;
  logic [10:0] rx_id;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  can_arb_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .id_in(id_in), .rtr_in(rtr_in),
    .bit_stb(bit_stb), .rx_bit(rx_bit), .frame_end(frame_end),
    .tx_bit(tx_bit), .busy(busy), .arb_won(arb_won), .arb_lost(arb_lost),
    .lost_pos(lost_pos), .bit_err(bit_err), .rx_done(rx_done),
    .rx_id(rx_id), .rx_rtr(rx_rtr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      total = total + 1;
      bad   = bad + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<%0d", cyc, WD_LIMIT);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // {dut id, dut rtr, other id, other rtr, dut wins, loss position}
  localparam logic [28:0] VEC [0:7] = '{
    {11'h123, 1'b0, 11'h124, 1'b0, 1'b1, 4'd0},
    {11'h124, 1'b0, 11'h123, 1'b0, 1'b0, 4'd9},
    {11'h000, 1'b0, 11'h7FF, 1'b1, 1'b1, 4'd0},
    {11'h7FF, 1'b1, 11'h000, 1'b0, 1'b0, 4'd1},
    {11'h2AA, 1'b1, 11'h2AA, 1'b0, 1'b0, 4'd12},
    {11'h2AA, 1'b0, 11'h2AA, 1'b0, 1'b1, 4'd0},
    {11'h07F, 1'b1, 11'h07E, 1'b1, 1'b0, 4'd11},
    {11'h400, 1'b0, 11'h3FF, 1'b1, 1'b0, 4'd1}
  };

  // Stuffed bus stream of one section
  logic s_bit   [0:31];
  logic s_stuff [0:31];
  int   s_nd    [0:31];
  int   s_len;

  task automatic build_stream(input logic [12:0] fr);
    logic last;
    int   run;
    last  = 1'b1;
    run   = 0;
    s_len = 0;
    for (int k = 0; k < 13; k++) begin
      logic b;
      b = fr[12-k];
      s_bit[s_len] = b; s_stuff[s_len] = 1'b0; s_nd[s_len] = k;
      s_len++;
      if (run == 0 || b != last) begin last = b; run = 1; end
      else run++;
      if (run == 5 && k != 12) begin
        s_bit[s_len] = ~last; s_stuff[s_len] = 1'b1; s_nd[s_len] = k + 1;
        s_len++;
        last = ~last;
        run  = 1;
      end
    end
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_start(input logic [10:0] id, input logic rtr);
    @(negedge clk);
    start = 1'b1; id_in = id; rtr_in = rtr;
    @(negedge clk);
    start = 1'b0;
  endtask

  // called at a negedge; returns at the next negedge
  task automatic drive_bit(input logic b);
    rx_bit  = b;
    bit_stb = 1'b1;
    @(negedge clk);
    bit_stb = 1'b0;
  endtask

  task automatic end_frame();
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; id_in = '0; rtr_in = 1'b0;
    bit_stb = 1'b0; rx_bit = 1'b1; frame_end = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: idle after reset
    chk("R1", "tx idle", int'(tx_bit), 1);
    chk("R1", "busy idle", int'(busy), 0);
    chk("R1", "pulses idle", int'({arb_won, arb_lost, bit_err, rx_done}), 0);

    // Vector table: two contending nodes, bench drives the resulting bus
    for (int v = 0; v < 8; v++) begin
      logic [10:0] d_id, o_id;
      logic        d_rtr, o_rtr, e_won;
      logic [3:0]  e_pos;
      logic [12:0] dfr, ofr;
      int txbad, nwon, nlost, ndone, nberr, won_last, lp;
      {d_id, d_rtr, o_id, o_rtr, e_won, e_pos} = VEC[v];
      dfr = {1'b0, d_id, d_rtr};
      ofr = {1'b0, o_id, o_rtr};
      chk("R6", "lower section wins", int'(dfr <= ofr), int'(e_won));
      build_stream(e_won ? dfr : ofr);
      lp = int'(e_pos);
      txbad = 0; nwon = 0; nlost = 0; ndone = 0; nberr = 0; won_last = 0;
      do_start(d_id, d_rtr);
      for (int i = 0; i < s_len; i++) begin
        logic exp_tx;
        if (e_won || (s_stuff[i] ? (s_nd[i] <= lp) : (s_nd[i] < lp))) exp_tx = s_bit[i];
        else exp_tx = 1'b1;
        if (tx_bit !== exp_tx) txbad++;
        drive_bit(s_bit[i]);
        if (arb_won)  begin nwon++; won_last = int'(i == s_len - 1); end
        if (arb_lost) nlost++;
        if (rx_done)  ndone++;
        if (bit_err)  nberr++;
        repeat (v % 3) @(negedge clk);
      end
      chk("R2 R3", "tx stream mismatches", txbad, 0);
      chk("R4", "won pulses", nwon, int'(e_won));
      chk("R5", "lost pulses", nlost, int'(!e_won));
      chk("R8", "no bit error", nberr, 0);
      if (e_won) begin
        chk("R4", "won after last bit", won_last, 1);
        chk("R4", "released after win", int'({busy, tx_bit}), 1);
      end else begin
        chk("R5", "lost_pos", int'(lost_pos), lp);
        chk("R7", "rx_done pulses", ndone, 1);
        chk("R7", "rx_id", int'(rx_id), int'(o_id));
        chk("R7", "rx_rtr", int'(rx_rtr), int'(o_rtr));
        chk("R5", "held recessive and busy", int'({busy, tx_bit}), 3);
        end_frame();
        chk("R10", "idle after frame_end", int'({busy, tx_bit}), 1);
      end
      @(negedge clk);
    end

    // R8: start bit read back recessive
    do_start(11'h123, 1'b0);
    chk("R2", "start bit dominant", int'(tx_bit), 0);
    drive_bit(1'b1);
    chk("R8", "bit_err on dominant mismatch", int'(bit_err), 1);
    chk("R8", "no loss on dominant mismatch", int'(arb_lost), 0);
    drive_bit(1'b0);
    chk("R8", "later strobe ignored", int'({tx_bit, busy, arb_lost, bit_err}), 4'b1100);
    end_frame();
    chk("R10", "idle after bit error", int'(busy), 0);

    // R9: stuff bit forced dominant
    do_start(11'h000, 1'b0);
    for (int i = 0; i < 5; i++) drive_bit(1'b0);
    chk("R3", "stuff bit recessive after five dominant", int'(tx_bit), 1);
    drive_bit(1'b0);
    chk("R9", "bit_err on stuff mismatch", int'(bit_err), 1);
    chk("R9", "no loss on stuff mismatch", int'(arb_lost), 0);
    end_frame();

    // R10: abort while sending
    do_start(11'h555, 1'b1);
    drive_bit(1'b0);
    end_frame();
    chk("R10", "abort mid-send", int'({busy, tx_bit}), 1);

    // R1: reset in the middle of a frame
    do_start(11'h000, 1'b0);
    drive_bit(1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "reset mid-frame", int'({busy, tx_bit}), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule